// File: doc/BRIEF.md
# Cascadable Serial Configuration Stream Reader

This block is the read side of a small configuration store. It streams a fixed bitstream to a downstream device, using a configuration clock that the downstream device supplies. The contents are computed at elaboration from a seed parameter. An address counter and a bit counter step through the store in order. Each enabled rising clock edge moves the stream on by one bit in narrow (serial) mode, or by one byte in wide (parallel) mode.

Several instances can share one clock and one data bus. Each instance's next-select output feeds the select input of the following instance. When an instance has given out its final bit, it releases the bus to high impedance. In the same moment it pulls next-select low, so the following instance takes the bus without a gap. A low level on the shared enable/reset input releases every bus driver at once. At the next clock edge it returns every counter to address zero.

Top module: `cfg_stream_rom`

## Requirements
- R1: In narrow mode (`wide_mode`=0), while driving, `dout[0]` carries bit (7−b) of the stored byte at address a. Here a is the current address and b is the bit count since the start of that byte, so bytes go out most significant bit first. `dout[7:1]` is 0.
- R2: In wide mode (`wide_mode`=1), while driving, `dout` carries the whole byte at the current address, and each valid edge moves on by one byte.
- R3: A rising edge of `cfg_clk` advances the position only when `sel_n`=0 and `enable_rst_n`=1. While `sel_n`=1, the position is held and the stream resumes exactly where it stopped.
- R4: The final item is the bit count 7 of the last address in narrow mode, or the last address in wide mode. The edge that consumes it sets the device to exhausted. From then on `dout_drive`=0 and `next_sel_n`=0, for as long as the device stays selected.
- R5: `dout_drive` is 1 exactly when `sel_n`=0, `enable_rst_n`=1 and the device is not exhausted. Otherwise `dout` is high impedance. With `sel_n` held low, the device keeps driving until it is exhausted.
- R6: While `enable_rst_n`=0, `dout_drive` is 0 at once. Each rising edge in that state clears the address, the bit count and the exhausted state, so the stream restarts at address 0, bit 0.
- R7: `next_sel_n` is 1 whenever `sel_n`=1 or `enable_rst_n`=0.
- R8: Stored byte i is ((i·29 + SEED) mod 256) XOR 0xA5, where i runs from 0 to DEPTH−1.
- R9: A chain of two instances delivers the full contents of the first and then of the second, in order, with no gap and no repeated item. Exactly one instance drives at every step of the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock, rising edge active |
| sel_n | input | 1 | Active-low select, from the upstream next-select or tied low |
| enable_rst_n | input | 1 | High enables output; low releases the bus and clears the counters |
| wide_mode | input | 1 | 0 = one bit per edge, 1 = one byte per edge |
| dout | output | 8 | Data bus, high impedance when not driving |
| dout_drive | output | 1 | High while this instance drives `dout` |
| next_sel_n | output | 1 | Active-low select for the next instance in the chain |

## Verification
The hand-off is where two functions land on the same edge. The edge that consumes the first device's final item also enables the second device's first item. The bench runs two chained instances with different seeds through that edge, in both modes. At every step it checks that exactly one device drives and that the bus item matches the expected sequence. A reset pulse dropped in the middle of the stream, and a select stall, are judged the same way: by the next item that appears on the bus.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = 3;

  function automatic logic [BYTE_W-1:0] pattern_byte(input int idx, input logic [7:0] seed);
    logic [BYTE_W-1:0] v;
    v = 8'(idx * 29) + seed;
    return v ^ 8'hA5;
  endfunction
endpackage

// File: rtl/cfg_rom.sv
module cfg_rom
  import cfg_stream_pkg::*;
#(
  parameter int          DEPTH = 16,
  parameter logic [7:0]  SEED  = 8'h00,
  localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0]     addr_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] mem [DEPTH];

  // contents are fixed at elaboration from the seed
  for (genvar i = 0; i < DEPTH; i++) begin : g_fill
    assign mem[i] = pattern_byte(i, SEED);
  end

  assign byte_o = mem[addr_i];
endmodule

// File: rtl/cfg_pos_ctr.sv
module cfg_pos_ctr
  import cfg_stream_pkg::*;
#(
  parameter int  DEPTH = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic             clk,
  input  logic             sel_n,
  input  logic             enable_rst_n,
  input  logic             wide_mode,
  output logic [AW-1:0]    addr_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             done_o
);
  logic adv;
  logic byte_end;

  assign adv      = !sel_n && enable_rst_n && !done_o;
  assign byte_end = wide_mode || (bit_o == BIT_W'(7));

  always_ff @(posedge clk) begin
    if (!enable_rst_n) begin
      addr_o <= '0;
      bit_o  <= '0;
      done_o <= 1'b0;
    end else if (adv) begin
      if (byte_end) begin
        bit_o <= '0;
        if (addr_o == LAST) done_o <= 1'b1;
        else                addr_o <= addr_o + AW'(1);
      end else begin
        bit_o <= bit_o + BIT_W'(1);
      end
    end
  end

  // R6
  rst_clear_chk: assert property (@(posedge clk)
    !enable_rst_n |=> (addr_o == '0 && bit_o == '0 && !done_o));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!enable_rst_n)
    sel_n |=> ($stable(addr_o) && $stable(bit_o) && $stable(done_o)));

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!enable_rst_n)
    done_o |=> done_o);

  // R4
  done_at_last_chk: assert property (@(posedge clk) disable iff (!enable_rst_n)
    done_o |-> (addr_o == LAST));

  // R2
  wide_bit_chk: assert property (@(posedge clk) disable iff (!enable_rst_n)
    (wide_mode && !sel_n) |=> (bit_o == '0));
endmodule

// File: rtl/cfg_out_sel.sv
module cfg_out_sel
  import cfg_stream_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              wide_mode,
  output logic [BYTE_W-1:0] val_o
);
  logic [BIT_W-1:0] pick;

  assign pick = BIT_W'(7) - bit_i;

  always_comb begin
    if (wide_mode) val_o = byte_i;
    else           val_o = {{(BYTE_W-1){1'b0}}, byte_i[pick]};
  end
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom
  import cfg_stream_pkg::*;
#(
  parameter int         DEPTH = 16,
  parameter logic [7:0] SEED  = 8'h00
) (
  input  logic       cfg_clk,
  input  logic       sel_n,
  input  logic       enable_rst_n,
  input  logic       wide_mode,
  output logic [7:0] dout,
  output logic       dout_drive,
  output logic       next_sel_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]     addr;
  logic [BIT_W-1:0]  bitc;
  logic              done;
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] out_val;

  cfg_pos_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk          (cfg_clk),
    .sel_n        (sel_n),
    .enable_rst_n (enable_rst_n),
    .wide_mode    (wide_mode),
    .addr_o       (addr),
    .bit_o        (bitc),
    .done_o       (done)
  );

  cfg_rom #(.DEPTH(DEPTH), .SEED(SEED)) u_rom (
    .addr_i (addr),
    .byte_o (rd_byte)
  );

  cfg_out_sel u_sel (
    .byte_i    (rd_byte),
    .bit_i     (bitc),
    .wide_mode (wide_mode),
    .val_o     (out_val)
  );

  assign dout_drive = !sel_n && enable_rst_n && !done;
  assign next_sel_n = !(done && !sel_n && enable_rst_n);
  assign dout       = dout_drive ? out_val : 8'bz;

  // R4
  handoff_chk: assert property (@(posedge cfg_clk) disable iff (!enable_rst_n)
    ($fell(next_sel_n) && $past(!sel_n)) |-> $past(dout_drive));
endmodule

// File: tb/cfg_stream_rom_tb.sv
module cfg_stream_rom_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH_TB   = 4;
  localparam logic [7:0] SEED0 = 8'h11;
  localparam logic [7:0] SEED1 = 8'h6C;
  localparam int BITS_DEV = DEPTH_TB * 8;

  logic clk = 1'b0;
  logic sel_n = 1'b1;
  logic en_rst_n = 1'b0;
  logic wide = 1'b0;
  wire [7:0] d0, d1;
  logic drv0, drv1, nsel0, nsel1;
  logic [7:0] bus;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_rom #(.DEPTH(DEPTH_TB), .SEED(SEED0)) u_dut (
    .cfg_clk(clk), .sel_n(sel_n), .enable_rst_n(en_rst_n), .wide_mode(wide),
    .dout(d0), .dout_drive(drv0), .next_sel_n(nsel0));

  cfg_stream_rom #(.DEPTH(DEPTH_TB), .SEED(SEED1)) u_dev1 (
    .cfg_clk(clk), .sel_n(nsel0), .enable_rst_n(en_rst_n), .wide_mode(wide),
    .dout(d1), .dout_drive(drv1), .next_sel_n(nsel1));

  assign bus = drv0 ? d0 : d1;

  function automatic logic [7:0] exp_byte(input int dev, input int idx);
    logic [7:0] s;
    logic [7:0] v;
    s = (dev == 0) ? SEED0 : SEED1;
    v = 8'((idx * 29) % 256) + s;
    return v ^ 8'hA5;
  endfunction

  function automatic logic exp_bit(input int g);
    logic [7:0] b;
    b = exp_byte(g / BITS_DEV, (g % BITS_DEV) / 8);
    return b[7 - (g % 8)];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic do_reset();
    en_rst_n = 1'b0;
    sel_n    = 1'b1;
    tick();
    tick();
    en_rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset_state();
    en_rst_n = 1'b0;
    sel_n    = 1'b0;
    tick();
    tick();
    chk(!drv0 && !drv1, "R6 no driver in reset", {drv0, drv1}, 0);
    chk(nsel0 == 1'b1, "R7 next_sel high in reset", nsel0, 1);
    en_rst_n = 1'b1;
    sel_n    = 1'b1;
    #1;
    chk(!drv0, "R5 deselected not driving", drv0, 0);
    chk(nsel0 == 1'b1, "R7 next_sel high when deselected", nsel0, 1);
  endtask

  task automatic t_serial_chain();
    do_reset();
    wide  = 1'b0;
    sel_n = 1'b0;
    #1;
    for (int g = 0; g < 2 * BITS_DEV; g++) begin
      if (g == BITS_DEV) begin
        chk(!drv0 && !nsel0, "R4 first device handed off", {drv0, nsel0}, 0);
      end
      chk((int'(drv0) + int'(drv1)) == 1, "R9 exactly one driver", {drv0, drv1}, 1);
      chk(bus[0] == exp_bit(g), "R1 R8 R9 serial bit", bus[0], exp_bit(g));
      chk(bus[7:1] == 7'd0, "R1 upper lines zero", bus[7:1], 0);
      tick();
    end
    chk(!drv0 && !drv1, "R4 chain exhausted releases bus", {drv0, drv1}, 0);
    chk(nsel1 == 1'b0, "R4 last device next_sel low", nsel1, 0);
  endtask

  task automatic t_stall();
    do_reset();
    wide  = 1'b0;
    sel_n = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    sel_n = 1'b1;
    #1;
    chk(!drv0 && !drv1, "R5 stall releases bus", {drv0, drv1}, 0);
    chk(nsel0 == 1'b1, "R7 stall next_sel high", nsel0, 1);
    for (int k = 0; k < 3; k++) tick();
    sel_n = 1'b0;
    #1;
    chk(drv0 && bus[0] == exp_bit(5), "R3 resume at bit 5", bus[0], exp_bit(5));
    tick();
    chk(bus[0] == exp_bit(6), "R3 advance after resume", bus[0], exp_bit(6));
  endtask

  task automatic t_mid_reset();
    do_reset();
    wide  = 1'b0;
    sel_n = 1'b0;
    for (int k = 0; k < 10; k++) tick();
    chk(bus[0] == exp_bit(10), "R1 position before reset", bus[0], exp_bit(10));
    en_rst_n = 1'b0;
    #1;
    chk(!drv0 && !drv1, "R6 reset releases bus at once", {drv0, drv1}, 0);
    tick();
    en_rst_n = 1'b1;
    #1;
    chk(drv0 && bus[0] == exp_bit(0), "R6 restart at bit 0", bus[0], exp_bit(0));
    tick();
    chk(bus[0] == exp_bit(1), "R6 continue from restart", bus[0], exp_bit(1));
  endtask

  task automatic t_wide_chain();
    do_reset();
    wide  = 1'b1;
    sel_n = 1'b0;
    #1;
    for (int j = 0; j < 2 * DEPTH_TB; j++) begin
      chk((int'(drv0) + int'(drv1)) == 1, "R9 wide one driver", {drv0, drv1}, 1);
      chk(bus == exp_byte(j / DEPTH_TB, j % DEPTH_TB), "R2 R8 wide byte",
          bus, exp_byte(j / DEPTH_TB, j % DEPTH_TB));
      tick();
    end
    chk(!drv0 && !drv1 && !nsel1, "R4 wide chain exhausted", {drv0, drv1, nsel1}, 0);
    wide = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    #1;
    t_reset_state();
    t_serial_chain();
    t_stall();
    t_mid_reset();
    t_wide_chain();
    report();
  end
endmodule